// File: doc/BRIEF.md
# Split-Half Bidirectional Port with Address Bus Override

This block is a 16-bit general purpose I/O port made of two independent 8-bit halves. Each half has its own output latch and its own direction register. Software reaches all four registers through a small register bus that has byte-lane strobes. The pads appear as three separate vectors: driven value, driver enable and sensed level.

When the bus controller raises its demultiplexed-bus request, the port hands all sixteen pads over to it. Every line becomes an output, and the pad latch is loaded each cycle from the 16-bit alternate address input instead of the register bus. Software writes made during this time still land in the register latches. They show up on the pads once the request drops.

The four uppermost lines also feed a capture stage that works as external interrupt inputs. The stage synchronises these lines, samples them once every eight clocks and raises a one-clock pulse on each selected edge.

Top module: `split_gpio_port`

## Requirements
- R1: After synchronous reset, `pin_oe` and `pin_out` are all zero, and both direction registers read back as zero.
- R2: A write to one half's data latch leaves the other half's latch unchanged. Outside override, `pin_out` shows the latch in the cycle after the write edge.
- R3: `reg_addr` selects a register: 0 is low data, 1 is high data, 2 is low direction, 3 is high direction.
  - Low registers take `reg_wdata[7:0]`, and only when `reg_lane[0]`=1.
  - High registers take `reg_wdata[15:8]`, and only when `reg_lane[1]`=1.
  - A write whose lane strobe does not match has no effect.
  - A read returns the register in its own byte lane, with the other byte zero.
- R4: Outside override, `pin_oe[i]` equals direction bit i. A value of 1 drives the line, and 0 leaves it an undriven input.
- R5: A data read returns, bit by bit, the latch value for output lines and `pin_in` for input lines.
- R6: Suppose `bus_demux_en` is 1 at a clock edge. In the following cycle `pin_oe` is all ones, and `pin_out` equals `alt_addr` as it was sampled at that edge.
- R7: Data writes made during override are kept. After an edge with `bus_demux_en`=0, `pin_out` shows the latest written latch values again, and `pin_oe` follows the direction registers again.
- R8: During override, a data read returns the alternate address value held in the pad latch.
- R9: Suppose a change on one of `pin_in[15:12]` is held for 16 cycles. It gives exactly one pulse, one cycle wide, on the matching `cap_pulse` bit when the edge is selected, and none when it is not.
- R10: `cap_edge_sel[2i+1:2i]` selects the edge for capture line i: 00 disabled, 01 rising, 10 falling, 11 both.
- R11: Capture lines are sampled every 8 clocks. A pulse can only appear in the cycle after clock edge 8k counted from reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write request |
| reg_addr | input | 2 | Register select |
| reg_lane | input | 2 | Byte-lane strobes |
| reg_wdata | input | 16 | Write data, low byte then high byte |
| reg_rdata | output | 16 | Read data (combinational) |
| bus_demux_en | input | 1 | Bus controller override request |
| alt_addr | input | 16 | Alternate address for the pad latch |
| cap_edge_sel | input | 8 | Edge select, 2 bits per capture line |
| pin_in | input | 16 | Sensed pad levels |
| pin_out | output | 16 | Pad drive values |
| pin_oe | output | 16 | Pad driver enables |
| cap_pulse | output | 4 | Capture/interrupt pulses for lines 15..12 |

## Verification
The hardest situation to reach is software writing the data latch while the bus controller owns the pads, and then the override dropping. The pads must then switch straight to the shadowed values.

The random phase holds `bus_demux_en` in runs that flip with low probability, so writes often fall inside override windows and releases happen with fresh shadow data. A directed sequence forces this case for both halves.

Capture edges are driven by holding each new nibble for sixteen cycles. This way every change meets exactly one sampling point, whatever the phase of the divider.

// File: rtl/bport_pkg.sv
package bport_pkg;

    localparam int HALF_W_DEF     = 8;
    localparam int CAP_LINES_DEF  = 4;
    localparam int SAMPLE_DIV_DEF = 8;

    typedef enum logic [1:0] {
        SEL_DATA_LO = 2'd0,
        SEL_DATA_HI = 2'd1,
        SEL_DIR_LO  = 2'd2,
        SEL_DIR_HI  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic data_we;
        logic dir_we;
    } half_we_t;

    function automatic logic edge_hit(logic prev, logic cur, edge_mode_e mode);
        case (mode)
            EDGE_RISE: return !prev && cur;
            EDGE_FALL: return prev && !cur;
            EDGE_ANY:  return prev ^ cur;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bport_half.sv
module bport_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         data_we,
    input  logic         dir_we,
    input  logic [W-1:0] wdata,
    input  logic         ovr,
    input  logic         alt_load,
    input  logic [W-1:0] alt_in,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] rd_dir
);

    logic [W-1:0] sw_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] alt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q  <= '0;
            dir_q <= '0;
            alt_q <= '0;
        end else begin
            if (data_we)  sw_q  <= wdata;
            if (dir_we)   dir_q <= wdata;
            if (alt_load) alt_q <= alt_in;
        end
    end

    assign pin_oe  = ovr ? {W{1'b1}} : dir_q;
    assign pin_out = ovr ? alt_q : sw_q;
    assign rd_data = (pin_oe & pin_out) | (~pin_oe & pin_in);
    assign rd_dir  = dir_q;

    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(data_we) && !$past(rst)) |-> $stable(sw_q)); // R2

    AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($past(data_we) && !$past(rst)) |-> (sw_q == $past(wdata))); // R7

endmodule

// File: rtl/bport_capture.sv
module bport_capture
    import bport_pkg::*;
#(
    parameter int LINES = 4,
    parameter int DIV   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LINES-1:0]   lines_in,
    input  logic [2*LINES-1:0] edge_sel,
    output logic [LINES-1:0]   pulse
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0]    cnt;
    logic             tick;
    logic [LINES-1:0] sync1, sync2, samp, hit, pulse_q;

    assign tick = (cnt == CW'(DIV - 1));

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            hit[i] = edge_hit(samp[i], sync2[i], edge_mode_e'(edge_sel[2*i +: 2]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            sync1   <= '0;
            sync2   <= '0;
            samp    <= '0;
            pulse_q <= '0;
        end else begin
            cnt     <= tick ? '0 : cnt + CW'(1);
            sync1   <= lines_in;
            sync2   <= sync1;
            if (tick) samp <= sync2;
            pulse_q <= tick ? hit : '0;
        end
    end

    assign pulse = pulse_q;

    AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (|pulse_q) |-> $past(tick)); // R11

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (|pulse_q) |=> !(|pulse_q)); // R9

endmodule

// File: rtl/split_gpio_port.sv
module split_gpio_port
    import bport_pkg::*;
#(
    parameter int HALF_W     = HALF_W_DEF,
    parameter int CAP_LINES  = CAP_LINES_DEF,
    parameter int SAMPLE_DIV = SAMPLE_DIV_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_we,
    input  logic [1:0]             reg_addr,
    input  logic [1:0]             reg_lane,
    input  logic [2*HALF_W-1:0]    reg_wdata,
    output logic [2*HALF_W-1:0]    reg_rdata,
    input  logic                   bus_demux_en,
    input  logic [2*HALF_W-1:0]    alt_addr,
    input  logic [2*CAP_LINES-1:0] cap_edge_sel,
    input  logic [2*HALF_W-1:0]    pin_in,
    output logic [2*HALF_W-1:0]    pin_out,
    output logic [2*HALF_W-1:0]    pin_oe,
    output logic [CAP_LINES-1:0]   cap_pulse
);

    localparam int PORT_W = 2 * HALF_W;
    localparam int N_HALF = 2;

    logic                          ovr_q;
    half_we_t [N_HALF-1:0]         we_h;
    logic [N_HALF-1:0][HALF_W-1:0] rd_data_h;
    logic [N_HALF-1:0][HALF_W-1:0] rd_dir_h;
    reg_sel_e                      sel;

    assign sel = reg_sel_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) ovr_q <= 1'b0;
        else     ovr_q <= bus_demux_en;
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        localparam reg_sel_e DSEL = (h == 0) ? SEL_DATA_LO : SEL_DATA_HI;
        localparam reg_sel_e RSEL = (h == 0) ? SEL_DIR_LO  : SEL_DIR_HI;

        assign we_h[h].data_we = reg_we && reg_lane[h] && (sel == DSEL);
        assign we_h[h].dir_we  = reg_we && reg_lane[h] && (sel == RSEL);

        bport_half #(.W(HALF_W)) i_half (
            .clk      (clk),
            .rst      (rst),
            .data_we  (we_h[h].data_we),
            .dir_we   (we_h[h].dir_we),
            .wdata    (reg_wdata[h*HALF_W +: HALF_W]),
            .ovr      (ovr_q),
            .alt_load (bus_demux_en),
            .alt_in   (alt_addr[h*HALF_W +: HALF_W]),
            .pin_in   (pin_in[h*HALF_W +: HALF_W]),
            .pin_out  (pin_out[h*HALF_W +: HALF_W]),
            .pin_oe   (pin_oe[h*HALF_W +: HALF_W]),
            .rd_data  (rd_data_h[h]),
            .rd_dir   (rd_dir_h[h])
        );
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_DATA_LO: reg_rdata[HALF_W-1:0]      = rd_data_h[0];
            SEL_DATA_HI: reg_rdata[PORT_W-1:HALF_W] = rd_data_h[1];
            SEL_DIR_LO:  reg_rdata[HALF_W-1:0]      = rd_dir_h[0];
            default:     reg_rdata[PORT_W-1:HALF_W] = rd_dir_h[1];
        endcase
    end

    bport_capture #(.LINES(CAP_LINES), .DIV(SAMPLE_DIV)) i_capture (
        .clk      (clk),
        .rst      (rst),
        .lines_in (pin_in[PORT_W-1 -: CAP_LINES]),
        .edge_sel (cap_edge_sel),
        .pulse    (cap_pulse)
    );

    AST_RESET_HIZ: assert property (@(posedge clk)
        $fell(rst) |-> (pin_oe == '0 && pin_out == '0)); // R1

    AST_BUS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_demux_en) && !$past(rst)) |-> ((&pin_oe) && pin_out == $past(alt_addr))); // R6

endmodule

// File: tb/test_split_gpio_port.sv
`timescale 1ns/1ps
module test_split_gpio_port;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [1:0]  reg_lane = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_demux_en = 1'b0;
    logic [15:0] alt_addr = '0;
    logic [7:0]  cap_edge_sel = '0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [3:0]  cap_pulse;

    int nchk = 0;
    int nerr = 0;
    int ecnt = 0;
    int pcount [4];
    logic [15:0] m_sw = '0, m_dir = '0, m_alt = '0;
    logic        m_ovr = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) ecnt <= 0;
        else     ecnt <= ecnt + 1;
    end

    split_gpio_port i_split_gpio_port (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_lane(reg_lane), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_demux_en(bus_demux_en), .alt_addr(alt_addr),
        .cap_edge_sel(cap_edge_sel), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .cap_pulse(cap_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_hit(logic p, logic c, logic [1:0] s);
        case (s)
            2'd1:    return !p && c;
            2'd2:    return p && !c;
            2'd3:    return p ^ c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] exp_oe();
        return m_ovr ? 16'hFFFF : m_dir;
    endfunction

    function automatic logic [15:0] exp_out();
        return m_ovr ? m_alt : m_sw;
    endfunction

    function automatic logic [15:0] exp_rd();
        logic [15:0] mix;
        mix = (exp_oe() & exp_out()) | (~exp_oe() & pin_in);
        case (reg_addr)
            2'd0:    return {8'h00, mix[7:0]};
            2'd1:    return {mix[15:8], 8'h00};
            2'd2:    return {8'h00, m_dir[7:0]};
            default: return {m_dir[15:8], 8'h00};
        endcase
    endfunction

    // Inputs are set just after a falling edge; checks run 1 ns later, then the model advances.
    task automatic do_cycle();
        #1;
        chk(m_ovr ? "R6" : "R4", pin_oe, exp_oe());
        chk(m_ovr ? "R6" : "R2", pin_out, exp_out());
        if (reg_addr[1]) chk("R3", reg_rdata, exp_rd());
        else             chk(m_ovr ? "R8" : "R5", reg_rdata, exp_rd());
        if (|cap_pulse) chk("R11", ecnt % 8, 0);
        for (int i = 0; i < 4; i++) pcount[i] += int'(cap_pulse[i]);
        m_ovr = bus_demux_en;
        if (bus_demux_en) m_alt = alt_addr;
        if (reg_we) begin
            case (reg_addr)
                2'd0: if (reg_lane[0]) m_sw[7:0]   = reg_wdata[7:0];
                2'd1: if (reg_lane[1]) m_sw[15:8]  = reg_wdata[15:8];
                2'd2: if (reg_lane[0]) m_dir[7:0]  = reg_wdata[7:0];
                default: if (reg_lane[1]) m_dir[15:8] = reg_wdata[15:8];
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] ln, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_lane = ln; reg_wdata = d;
        do_cycle();
        reg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", pin_oe, 16'h0000);
        chk("R1", pin_out, 16'h0000);
        reg_addr = 2'd2;
        #1 chk("R1", reg_rdata, 16'h0000);
        reg_addr = 2'd3;
        #1 chk("R1", reg_rdata, 16'h0000);
        @(negedge clk);

        // R2: low write leaves high latch alone
        wr(2'd2, 2'b01, 16'h00FF);
        wr(2'd3, 2'b10, 16'hFF00);
        wr(2'd1, 2'b10, 16'hA500);
        wr(2'd0, 2'b01, 16'h003C);
        #1 chk("R2", pin_out, 16'hA53C);
        @(negedge clk);
        // R3: lane mismatch ignored
        wr(2'd0, 2'b10, 16'h7777);
        wr(2'd1, 2'b01, 16'h8888);
        #1 chk("R3", pin_out, 16'hA53C);
        @(negedge clk);

        // R7: writes during override, then release
        bus_demux_en = 1'b1; alt_addr = 16'h1234;
        do_cycle();
        #1 chk("R6", pin_out, 16'h1234);
        @(negedge clk);
        wr(2'd0, 2'b01, 16'h005A);
        wr(2'd1, 2'b10, 16'hC300);
        #1 chk("R7", pin_out, 16'h1234);
        @(negedge clk);
        bus_demux_en = 1'b0;
        do_cycle();
        #1 chk("R7", pin_out, 16'hC35A);
        @(negedge clk);

        // Random register and override traffic
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(7) == 0) bus_demux_en = ~bus_demux_en;
            alt_addr  = 16'($urandom);
            reg_we    = ($urandom_range(2) != 0);
            reg_addr  = 2'($urandom);
            reg_lane  = 2'($urandom);
            reg_wdata = 16'($urandom);
            pin_in    = 16'($urandom);
            do_cycle();
        end
        reg_we = 1'b0; bus_demux_en = 1'b0;

        // Capture: settle with all lines low
        pin_in[15:12] = 4'h0; cap_edge_sel = 8'h00;
        repeat (16) do_cycle();

        for (int c = 0; c < 30; c++) begin
            logic [3:0] oldv, newv;
            logic [7:0] sel;
            oldv = pin_in[15:12];
            case (c)
                0:       begin newv = 4'hF;         sel = 8'h55; end
                1:       begin newv = 4'h0;         sel = 8'hAA; end
                2:       begin newv = 4'hF;         sel = 8'h00; end
                3:       begin newv = 4'h0;         sel = 8'h55; end
                4:       begin newv = 4'hA;         sel = 8'hFF; end
                default: begin newv = 4'($urandom); sel = 8'($urandom); end
            endcase
            cap_edge_sel = sel;
            pin_in[15:12] = newv;
            for (int i = 0; i < 4; i++) pcount[i] = 0;
            repeat (16) do_cycle();
            for (int i = 0; i < 4; i++)
                chk((c < 5) ? "R10" : "R9", pcount[i],
                    exp_hit(oldv[i], newv[i], sel[2*i +: 2]) ? 1 : 0);
        end

        finish_run();
    end

endmodule